// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block turns the system clock into the serial clock waveform of an I2C master. A programmable power-of-two prescaler first produces a base tick. The SCL low phase and high phase are then counted in base ticks, each from its own field. Both phase fields are stored as one less than the length they give, so a field of zero still yields a phase of one tick. All three values come from a single 32-bit timing word. The SCL frequency is the system clock divided by `2^div * (lo + 1 + hi + 1)`.

Alongside the SCL level, the block emits one-cycle strobes on every falling edge, every rising edge and the middle of every high phase. A byte engine uses these strobes to drive and sample SDA. The top twelve bits of the timing word carry other bus timing values that belong to the neighbouring logic. They reach an output unchanged. A new timing word is taken only at the start of an SCL period, so a reprogramming never produces a shortened or stretched phase.

A build-time width parameter selects the phase field size. It is 4 bits by default. The narrow variant uses 3 bits, which halves the longest possible period.

Top module: `scl_timing_gen`

## Requirements
- R1: While `en` is low, from the next clock edge onwards, `scl` is 1, `tick`, `scl_fall`, `scl_rise` and `scl_mid` are 0, and all counters return to zero.
- R2: While enabled, `tick` pulses for one cycle every `2^div` cycles. `div` is the timing word bits [3:0].
- R3: SCL stays low for `(lo + 1) * 2^div` cycles. `lo` is bits [12+PH_W-1:12] of the timing word.
- R4: SCL stays high for `(hi + 1) * 2^div` cycles between a rising edge and the next falling edge. `hi` is bits [16+PH_W-1:16].
- R5: A phase field of 0 gives a phase of exactly one base tick. With all three fields at 0, SCL toggles every cycle.
- R6: After `en` is first sampled high at clock edge E, the first SCL fall happens at edge E + 2^div - 1, which is the first base tick.
- R7: `scl_fall` and `scl_rise` are one-cycle strobes that are high in exactly the first cycle after SCL has fallen or risen.
- R8: `scl_mid` pulses once per high phase, `((hi + 1) >> 1) * 2^div` cycles after the rising edge. When `hi` is 0 it coincides with `scl_rise`.
- R9: A change of the timing word during a period takes effect only from the next falling edge of SCL. The current low and high phases and the tick spacing keep the old values.
- R10: `aux_timing` always equals timing word bits [31:20], combinationally.
- R11: With PH_W = 3, bits 15 and 19 of the timing word are ignored and the phase fields are bits [14:12] and [18:16].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| en | input | 1 | Generator enable; when low, SCL idles high |
| timing_word | input | WORD_W | Prescaler exponent, low and high phase fields, and pass-through fields |
| tick | output | 1 | Base tick strobe |
| scl | output | 1 | Serial clock level |
| scl_rise | output | 1 | Strobe in the first cycle of SCL high |
| scl_fall | output | 1 | Strobe in the first cycle of SCL low |
| scl_mid | output | 1 | Strobe at the middle of each high phase |
| aux_timing | output | WORD_W-20 | Upper timing fields passed through unchanged |

## Verification
The hardest case to reach is a timing word that changes in the middle of a period. The new divisor and phase counts must not leak into the phase already under way, and they must apply exactly at the following fall. The stimulus reaches this case by enabling with one word and writing a second word just after the first falling strobe. The expected event list is then built from the old values up to the second fall and from the new values after it. A second hard case is a disable in the middle of the low phase followed by a fresh enable. The fresh enable must see the prescaler restart, so its first fall lands exactly one base period after the enable.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

  // Field positions inside the timing word; a neighbouring block decodes
  // the same word, so these offsets are part of the behaviour.
  localparam int DIV_LSB   = 0;
  localparam int LO_LSB    = 12;
  localparam int HI_LSB    = 16;
  localparam int AUX_LSB   = 20;
  localparam int SLOT_W    = 4;   // room reserved for each phase field

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_e;

endpackage

// File: rtl/scl_cfg_latch.sv
module scl_cfg_latch #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_in,
  input  logic [PH_W-1:0]  lo_in,
  input  logic [PH_W-1:0]  hi_in,
  output logic [DIV_W-1:0] div_q,
  output logic [PH_W-1:0]  lo_q,
  output logic [PH_W-1:0]  hi_q
);

  logic [DIV_W-1:0] div_d;
  logic [PH_W-1:0]  lo_d;
  logic [PH_W-1:0]  hi_d;

  always_comb begin
    div_d = div_q;
    lo_d  = lo_q;
    hi_d  = hi_q;
    if (load) begin
      div_d = div_in;
      lo_d  = lo_in;
      hi_d  = hi_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else begin
      div_q <= div_d;
      lo_q  <= lo_d;
      hi_q  <= hi_d;
    end
  end

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  // Largest exponent is 2^DIV_W - 1, so that many bits hold the count.
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  always_comb begin
    limit = CNT_W'((64'd1 << div) - 64'd1);
    tick  = en && (cnt_q == limit);
    cnt_d = cnt_q;
    if (!en) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
  import scl_tg_pkg::*;
#(
  parameter int PH_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic [PH_W-1:0] lo,
  input  logic [PH_W-1:0] hi,
  output logic            scl,
  output logic            scl_rise,
  output logic            scl_fall,
  output logic            scl_mid,
  output logic            cfg_load
);

  phase_e          state_q, state_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic            scl_d, rise_d, fall_d, mid_d;
  logic [PH_W:0]   cnt_inc;
  logic [PH_W:0]   half;
  logic            high_done;

  always_comb begin
    cnt_inc   = {1'b0, cnt_q} + {{PH_W{1'b0}}, 1'b1};
    half      = ({1'b0, hi} + {{PH_W{1'b0}}, 1'b1}) >> 1;
    high_done = (state_q == PH_HIGH) && tick && (cnt_q == hi);
    // The timing word is taken while idle and at each period boundary.
    cfg_load  = (state_q == PH_IDLE) || high_done;

    state_d = state_q;
    cnt_d   = cnt_q;
    scl_d   = scl;
    rise_d  = 1'b0;
    fall_d  = 1'b0;
    mid_d   = 1'b0;

    if (!en) begin
      state_d = PH_IDLE;
      cnt_d   = '0;
      scl_d   = 1'b1;
    end else if (tick) begin
      case (state_q)
        PH_IDLE: begin
          state_d = PH_LOW;
          cnt_d   = '0;
          scl_d   = 1'b0;
          fall_d  = 1'b1;
        end
        PH_LOW: begin
          if (cnt_q == lo) begin
            state_d = PH_HIGH;
            cnt_d   = '0;
            scl_d   = 1'b1;
            rise_d  = 1'b1;
            mid_d   = (half == '0);
          end else begin
            cnt_d = cnt_inc[PH_W-1:0];
          end
        end
        PH_HIGH: begin
          if (cnt_q == hi) begin
            state_d = PH_LOW;
            cnt_d   = '0;
            scl_d   = 1'b0;
            fall_d  = 1'b1;
          end else begin
            cnt_d = cnt_inc[PH_W-1:0];
            mid_d = (cnt_inc == half);
          end
        end
        default: begin
          state_d = PH_IDLE;
          cnt_d   = '0;
          scl_d   = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= PH_IDLE;
      cnt_q    <= '0;
      scl      <= 1'b1;
      scl_rise <= 1'b0;
      scl_fall <= 1'b0;
      scl_mid  <= 1'b0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      scl      <= scl_d;
      scl_rise <= rise_d;
      scl_fall <= fall_d;
      scl_mid  <= mid_d;
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_tg_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 4,
  parameter int PH_W   = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      en,
  input  logic [WORD_W-1:0]         timing_word,
  output logic                      tick,
  output logic                      scl,
  output logic                      scl_rise,
  output logic                      scl_fall,
  output logic                      scl_mid,
  output logic [WORD_W-AUX_LSB-1:0] aux_timing
);

  localparam int GAP_LSB = DIV_LSB + DIV_W;
  localparam int GAP_W   = LO_LSB - GAP_LSB;

  logic [DIV_W-1:0] cfg_div;
  logic [PH_W-1:0]  cfg_lo;
  logic [PH_W-1:0]  cfg_hi;
  logic             cfg_load;

  // Upper timing fields belong to the neighbouring logic.
  assign aux_timing = timing_word[WORD_W-1:AUX_LSB];

  logic unused_gap;
  assign unused_gap = ^timing_word[GAP_LSB +: GAP_W];

  generate
    if (PH_W < SLOT_W) begin : g_narrow
      logic unused_slot;
      assign unused_slot = ^{timing_word[HI_LSB+PH_W +: SLOT_W-PH_W],
                             timing_word[LO_LSB+PH_W +: SLOT_W-PH_W]};
    end
  endgenerate

  scl_cfg_latch #(.DIV_W(DIV_W), .PH_W(PH_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .div_in (timing_word[DIV_LSB +: DIV_W]),
    .lo_in  (timing_word[LO_LSB +: PH_W]),
    .hi_in  (timing_word[HI_LSB +: PH_W]),
    .div_q  (cfg_div),
    .lo_q   (cfg_lo),
    .hi_q   (cfg_hi)
  );

  scl_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .div   (cfg_div),
    .tick  (tick)
  );

  scl_phase_fsm #(.PH_W(PH_W)) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .tick     (tick),
    .lo       (cfg_lo),
    .hi       (cfg_hi),
    .scl      (scl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .scl_mid  (scl_mid),
    .cfg_load (cfg_load)
  );

endmodule

// File: rtl/scl_timing_chk.sv
module scl_timing_chk #(
  parameter int DIV_W = 4,
  parameter int PH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             tick,
  input logic             scl,
  input logic             scl_rise,
  input logic             scl_fall,
  input logic             scl_mid,
  input logic [DIV_W-1:0] cfg_div,
  input logic [PH_W-1:0]  cfg_lo,
  input logic [PH_W-1:0]  cfg_hi
);

  logic [31:0]      gap, low_len, high_len;
  logic             seen_tick, seen_rise;
  logic [DIV_W-1:0] div_at_rise;
  logic [PH_W-1:0]  hi_at_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap         <= '0;
      seen_tick   <= 1'b0;
      seen_rise   <= 1'b0;
      low_len     <= '0;
      high_len    <= '0;
      div_at_rise <= '0;
      hi_at_rise  <= '0;
    end else begin
      if (!en) begin
        gap       <= '0;
        seen_tick <= 1'b0;
      end else if (tick) begin
        gap       <= 32'd1;
        seen_tick <= 1'b1;
      end else begin
        gap <= gap + 32'd1;
      end
      if (!en) begin
        seen_rise <= 1'b0;
      end else if (scl_rise) begin
        seen_rise   <= 1'b1;
        div_at_rise <= cfg_div;
        hi_at_rise  <= cfg_hi;
      end
      low_len  <= scl ? 32'd0 : low_len + 32'd1;
      high_len <= scl ? high_len + 32'd1 : 32'd0;
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (scl && !scl_rise && !scl_fall && !scl_mid));

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_tick) |-> (gap == (32'd1 << cfg_div)));

  // R3
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> (low_len == ((32'(cfg_lo) + 32'd1) << cfg_div)));

  // R4
  high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_fall && seen_rise) |-> (high_len == ((32'(hi_at_rise) + 32'd1) << div_at_rise)));

  // R7
  fall_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_fall |-> $fell(scl));

  // R7
  fall_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl) |-> scl_fall);

  // R7
  rise_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_rise |-> $rose(scl));

  // R7
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({scl_rise, scl_fall}));

  // R8
  mid_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_mid |-> scl);

endmodule

bind scl_timing_gen scl_timing_chk #(.DIV_W(DIV_W), .PH_W(PH_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .tick     (tick),
  .scl      (scl),
  .scl_rise (scl_rise),
  .scl_fall (scl_fall),
  .scl_mid  (scl_mid),
  .cfg_div  (cfg_div),
  .cfg_lo   (cfg_lo),
  .cfg_hi   (cfg_hi)
);

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [31:0] word = '0;
  logic        tick, scl, scl_rise, scl_fall, scl_mid;
  logic [11:0] aux;
  logic        tick_n, scl_n, rise_n, fall_n, mid_n;
  logic [11:0] aux_n;

  int     checks = 0;
  int     errors = 0;
  longint cyc = 0;

  int     kq[$];
  longint tq[$];
  string  rq[$];

  scl_timing_gen dut (
    .clk(clk), .rst_n(rst_n), .en(en), .timing_word(word),
    .tick(tick), .scl(scl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .scl_mid(scl_mid), .aux_timing(aux)
  );

  scl_timing_gen #(.PH_W(3)) dut_n (
    .clk(clk), .rst_n(rst_n), .en(en), .timing_word(word),
    .tick(tick_n), .scl(scl_n), .scl_rise(rise_n), .scl_fall(fall_n),
    .scl_mid(mid_n), .aux_timing(aux_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung at cycle %0d, expected end before 100000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic logic [31:0] mk(int div, int lo, int hi, logic [11:0] top);
    return {top, 4'(hi), 4'(lo), 8'h00, 4'(div)};
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor side of the scoreboard. Kinds: 0 fall, 1 rise, 2 mid.
  task automatic see(int k);
    checks++;
    if (kq.size() == 0) begin
      errors++;
      $display("FAIL R7 unexpected event: actual kind %0d at cycle %0d, expected none", k, cyc);
    end else begin
      int     ek;
      longint et;
      string  r;
      ek = kq.pop_front();
      et = tq.pop_front();
      r  = rq.pop_front();
      if (ek != k || et != cyc) begin
        errors++;
        $display("FAIL %s event: actual kind %0d at cycle %0d, expected kind %0d at cycle %0d",
                 r, k, cyc, ek, et);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (scl_fall) see(0);
      if (scl_rise) see(1);
      if (scl_mid)  see(2);
    end
  end

  task automatic push(int k, longint t, string r);
    kq.push_back(k);
    tq.push_back(t);
    rq.push_back(r);
  endtask

  // Driver side: one full period starting with the fall at cycle f.
  task automatic push_period(inout longint f, input int div, input int lo, input int hi,
                             input string tag);
    longint d, r;
    d = longint'(1) << div;
    push(0, f, {"R4 R6 ", tag});
    r = f + (lo + 1) * d;
    push(1, r, {"R3 ", tag});
    push(2, r + ((hi + 1) / 2) * d, {"R8 ", tag});
    f = r + (hi + 1) * d;
  endtask

  task automatic run(input logic [31:0] w, input int nper, input string tag);
    longint f, c0;
    int div, lo, hi;
    div = int'(w[3:0]);
    lo  = int'(w[15:12]);
    hi  = int'(w[19:16]);
    @(negedge clk); word = w;
    @(negedge clk);
    @(negedge clk);
    c0 = cyc;
    f  = c0 + (longint'(1) << div);
    for (int i = 0; i < nper; i++) push_period(f, div, lo, hi, tag);
    en = 1'b1;
    while (cyc < f - 1) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic tick_gap(int exp_gap, int n);
    longint last;
    do @(negedge clk); while (!tick);
    last = cyc;
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!tick);
      chk(cyc - last == exp_gap, "R2", "tick spacing", cyc - last, exp_gap);
      last = cyc;
    end
  endtask

  task automatic narrow_probe();
    longint tf, tr, tf2;
    do @(negedge clk); while (!fall_n);
    tf = cyc;
    do @(negedge clk); while (!rise_n);
    tr = cyc;
    do @(negedge clk); while (!fall_n);
    tf2 = cyc;
    chk(tr - tf == 3, "R11", "narrow low length", tr - tf, 3);
    chk(tf2 - tr == 2, "R11", "narrow high length", tf2 - tr, 2);
  endtask

  initial begin
    longint c0, f;
    repeat (3) @(negedge clk);
    chk(scl == 1'b1, "R1", "scl in reset", scl, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(scl == 1'b1 && tick == 1'b0, "R1", "idle scl/tick after reset", {scl, tick}, 2);
    chk(!scl_rise && !scl_fall && !scl_mid, "R1", "idle strobes", {scl_rise, scl_fall, scl_mid}, 0);

    // R10 pass-through
    word = mk(2, 3, 4, 12'hA5C);
    #1;
    chk(aux == 12'hA5C, "R10", "aux field", aux, 12'hA5C);
    chk(aux_n == 12'hA5C, "R10", "aux field narrow", aux_n, 12'hA5C);

    // R5 all-zero fields: SCL toggles every cycle
    run(mk(0, 0, 0, 12'h000), 3, "R5");

    // R2 with a wider base tick
    fork
      run(mk(2, 3, 4, 12'h3C1), 2, "R2");
      tick_gap(4, 3);
    join
    chk(aux == 12'h3C1, "R10", "aux during run", aux, 12'h3C1);

    // R8 odd high count, mid at three ticks
    run(mk(1, 1, 5, 12'h000), 2, "R8");

    // R9 mid-period reprogramming: old word for period one, new after
    @(negedge clk); word = mk(1, 2, 1, 12'h000);
    @(negedge clk);
    @(negedge clk);
    c0 = cyc;
    f  = c0 + 2;
    push_period(f, 1, 2, 1, "R9");
    push_period(f, 0, 0, 3, "R9");
    push_period(f, 0, 0, 3, "R9");
    en = 1'b1;
    while (cyc < c0 + 3) @(negedge clk);
    word = mk(0, 0, 3, 12'h000);
    while (cyc < f - 1) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);

    // R1 disable in the middle of the low phase
    word = mk(1, 5, 0, 12'h000);
    @(negedge clk);
    @(negedge clk);
    c0 = cyc;
    push(0, c0 + 2, "R1 R6");
    en = 1'b1;
    while (cyc < c0 + 5) @(negedge clk);
    chk(scl == 1'b0, "R3", "scl low inside low phase", scl, 0);
    en = 1'b0;
    @(negedge clk);
    chk(scl == 1'b1, "R1", "scl after disable", scl, 1);
    chk(tick == 1'b0, "R1", "tick after disable", tick, 0);
    repeat (3) @(negedge clk);

    // R6 re-enable: counters restarted, first fall one base period later
    run(mk(1, 5, 0, 12'h000), 2, "R6");

    // R11 narrow variant ignores bits 15 and 19
    fork
      run(mk(0, 10, 9, 12'h000), 1, "R11");
      narrow_probe();
    join

    repeat (4) @(negedge clk);
    chk(kq.size() == 0, "R7", "missing events left in scoreboard", kq.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule